// File: doc/BRIEF.md
# Synchronous Serial Channel with Address-Match Wake-Up

This block moves one byte at a time over a synchronous serial link. Software controls it through three small registers on a CPU register bus: a mode register, the shift register, and a slave address register. Writing the shift register while the channel is enabled starts a transfer. The transfer then takes eight shift clocks, and each clock sends one bit on `sdo` and captures one bit from `sdi`. The shift clock comes from one of three sources: an external clock pin, a timer output, or a prescaled internal clock. All three are resynchronised into the system clock, and the channel acts on their rising edges.

At the end of each byte the channel may raise a one-cycle interrupt request. In the normal setting it raises one after every byte. With the wake-up filter armed, it raises one only when a separate bus-state detector reports both a detected command and a released bus, and the received byte also equals the programmed slave address. The filter lets a sleeping processor ignore bus traffic meant for other stations. A read-only flag in the mode register shows, at all times, whether the shift register equals the slave address. This flag reads 0 while the channel is disabled.

Top module: `sio_wake_chan`

## Requirements
- R1: After reset the mode register, the shift register and the slave address register all read 0x00, and `irq` and `sdo` are 0.
- R2: Mode bit 7 is the enable. While it is 0, shift clocks do not change the shift register and no interrupt is raised.
- R3: Mode bit 6 reads 1 when the slave address register equals the shift register, and 0 otherwise. Writes to bit 6 have no effect. Bits 7 and 5..0 read back as written.
- R4: Mode bit 6 reads 0 whenever the enable bit is 0, even if the two registers are equal.
- R5: When mode bit 5 (wake-up) is 0, every completed byte raises exactly one interrupt, in every mode.
- R6: When wake-up is 1, a completed byte raises an interrupt only if `cmd_det` and `bus_rel` are both 1 and the received byte equals the slave address. Otherwise it raises none.
- R7: When mode bits 4..3 are 11 (two-wire mode), wake-up is treated as 0 whatever bit 5 holds.
- R8: Mode bits 1..0 pick the shift clock: 0x selects `ext_sck`, 10 selects `tmr_clk`, and 11 selects `pre_clk`. Edges on the unselected inputs are ignored.
- R9: Bit order depends on the mode. Bits 4..3 = 10 (bus mode) and 11 (two-wire mode) shift MSB first. Bits 4..3 = 0x (three-wire mode) shift MSB first when bit 2 is 0 and LSB first when bit 2 is 1. `sdo` shows the outgoing bit, and `sdi` is captured on each shift clock.
- R10: A byte ends after exactly eight selected rising edges. The bit counter then returns to 0, and `irq` is a single-cycle pulse.
- R11: Writing the shift register (address 1) while the channel is enabled starts a transfer. Without such a write, shift clocks cause no shifting and no interrupt.
- R12: The slave address register (address 2) is readable and writable. Address 0 is the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 shift, 2 slave address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ext_sck | input | 1 | External shift clock pin |
| tmr_clk | input | 1 | Timer output used as a shift clock |
| pre_clk | input | 1 | Prescaled internal shift clock |
| sdi | input | 1 | Serial data in |
| cmd_det | input | 1 | Command-detected flag from the bus-state detector |
| bus_rel | input | 1 | Bus-released flag from the bus-state detector |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Transfer-complete interrupt pulse |

## Verification
The hardest situation to reach is the wake-up decision. It depends on the received byte matching the slave address at the same moment that both bus-condition flags are set. Random bytes almost never match, so the random stimulus copies the intended received byte into the slave address register for about half the transfers. Directed cases then switch off one flag at a time and arm wake-up in two-wire mode. Throughout, the unselected clock inputs toggle against the selected one, so that any leak from the clock selection would corrupt the captured byte.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  typedef enum logic [AW-1:0] {
    ADDR_MODE = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_SVA  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  localparam int BIT_EN    = 7;
  localparam int BIT_FLAG  = 6;
  localparam int BIT_WAKE  = 5;
  localparam int BIT_KIND1 = 4;
  localparam int BIT_KIND0 = 3;
  localparam int BIT_ORDER = 2;

  localparam logic [1:0] KIND_BUS = 2'b10;
  localparam logic [1:0] KIND_2W  = 2'b11;
endpackage

// File: rtl/sio_clk_sel.sv
module sio_clk_sel #(
  parameter int NSRC  = 3,
  parameter int SYNC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pins,
  input  logic [1:0]      sel,
  output logic            shift_edge
);
  logic [NSRC-1:0] synced;
  logic            lvl;
  logic            prev_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    logic [SYNC-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC-2:0], src_pins[g]};
    end
    assign synced[g] = chain_q[SYNC-1];
  end

  always_comb begin
    if (!sel[1])     lvl = synced[0];
    else if (sel[0]) lvl = synced[2];
    else             lvl = synced[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign shift_edge = lvl & ~prev_q;

  // R8: a rising edge is seen for one cycle only
  assert_edge_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_edge |=> !shift_edge);
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          lsb_first,
  input  logic          shift_edge,
  input  logic          sdi,
  output logic [DW-1:0] shreg,
  output logic [DW-1:0] shreg_nxt,
  output logic          sdo,
  output logic          done
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          busy_q, busy_nxt;
  logic          step;

  assign step = en & busy_q & shift_edge;

  always_comb begin
    shreg_nxt = sh_q;
    cnt_nxt   = cnt_q;
    busy_nxt  = busy_q;
    done      = 1'b0;
    if (!en) begin
      busy_nxt = 1'b0;
      cnt_nxt  = '0;
      if (load) shreg_nxt = load_data;
    end else if (load) begin
      shreg_nxt = load_data;
      busy_nxt  = 1'b1;
      cnt_nxt   = '0;
    end else if (step) begin
      shreg_nxt = lsb_first ? {sdi, sh_q[DW-1:1]} : {sh_q[DW-2:0], sdi};
      cnt_nxt   = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        done     = 1'b1;
        busy_nxt = 1'b0;
        cnt_nxt  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= shreg_nxt;
      cnt_q  <= cnt_nxt;
      busy_q <= busy_nxt;
    end
  end

  assign shreg = sh_q;
  assign sdo   = lsb_first ? sh_q[0] : sh_q[DW-1];

  // R10: counter back to zero and idle after the last bit
  assert_cnt_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt_q == '0) && !busy_q);
  // R2: a disabled channel does not shift
  assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(sh_q));
endmodule

// File: rtl/sio_wake_filter.sv
module sio_wake_filter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wake_req,
  input  logic          two_wire,
  input  logic          cmd_det,
  input  logic          bus_rel,
  input  logic          done,
  input  logic [DW-1:0] byte_nxt,
  input  logic [DW-1:0] shreg,
  input  logic [DW-1:0] sva,
  output logic          match_flag,
  output logic          irq
);
  logic wake_eff;
  logic fire;
  logic irq_q;

  assign match_flag = en & (shreg == sva);
  assign wake_eff   = wake_req & ~two_wire;
  assign fire       = done & (~wake_eff | (cmd_det & bus_rel & (byte_nxt == sva)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fire;
  end

  assign irq = irq_q;

  // R10: single-cycle interrupt pulse
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R6: a filtered interrupt needs both bus flags
  assert_wake_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(wake_eff)) |-> $past(cmd_det && bus_rel));
endmodule

// File: rtl/sio_wake_chan.sv
module sio_wake_chan
  import sio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ext_sck,
  input  logic          tmr_clk,
  input  logic          pre_clk,
  input  logic          sdi,
  input  logic          cmd_det,
  input  logic          bus_rel,
  output logic          sdo,
  output logic          irq
);
  logic [DW-1:0] mode_q, mode_nxt;
  logic [DW-1:0] sva_q, sva_nxt;
  logic [DW-1:0] shreg, shreg_nxt;
  logic          shift_edge, done, match_flag, load, lsb_first, two_wire;
  logic [1:0]    kind;

  assign kind      = mode_q[BIT_KIND1:BIT_KIND0];
  assign two_wire  = (kind == KIND_2W);
  assign lsb_first = ~kind[1] & mode_q[BIT_ORDER];
  assign load      = reg_we && (reg_addr == ADDR_DATA);

  always_comb begin
    mode_nxt = mode_q;
    sva_nxt  = sva_q;
    if (reg_we && reg_addr == ADDR_MODE) begin
      mode_nxt           = reg_wdata;
      mode_nxt[BIT_FLAG] = 1'b0;
    end
    if (reg_we && reg_addr == ADDR_SVA) sva_nxt = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sva_q  <= '0;
    end else begin
      mode_q <= mode_nxt;
      sva_q  <= sva_nxt;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_MODE: begin
        reg_rdata           = mode_q;
        reg_rdata[BIT_FLAG] = match_flag;
      end
      ADDR_DATA: reg_rdata = shreg;
      ADDR_SVA:  reg_rdata = sva_q;
      default:   reg_rdata = '0;
    endcase
  end

  sio_clk_sel #(.NSRC(3), .SYNC(2)) u_clk_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_pins   ({pre_clk, tmr_clk, ext_sck}),
    .sel        (mode_q[1:0]),
    .shift_edge (shift_edge)
  );

  sio_shifter #(.DW(DW)) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (mode_q[BIT_EN]),
    .load       (load),
    .load_data  (reg_wdata),
    .lsb_first  (lsb_first),
    .shift_edge (shift_edge),
    .sdi        (sdi),
    .shreg      (shreg),
    .shreg_nxt  (shreg_nxt),
    .sdo        (sdo),
    .done       (done)
  );

  sio_wake_filter #(.DW(DW)) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (mode_q[BIT_EN]),
    .wake_req   (mode_q[BIT_WAKE]),
    .two_wire   (two_wire),
    .cmd_det    (cmd_det),
    .bus_rel    (bus_rel),
    .done       (done),
    .byte_nxt   (shreg_nxt),
    .shreg      (shreg),
    .sva        (sva_q),
    .match_flag (match_flag),
    .irq        (irq)
  );

  // R4: flag reads low while disabled
  assert_flag_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[BIT_EN] && reg_addr == ADDR_MODE) |-> !reg_rdata[BIT_FLAG]);
  // R12: slave address write lands
  assert_sva_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_SVA) |=> sva_q == $past(reg_wdata));
  // R2: no interrupt while disabled
  assert_no_irq_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[BIT_EN] && !$past(mode_q[BIT_EN])) |-> !irq);
endmodule

// File: tb/sio_wake_chan_bench.sv
module sio_wake_chan_bench;
  localparam int PERIOD = 10;

  logic       clk, rst_n, reg_we, sdi, cmd_det, bus_rel, sdo, irq;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [2:0] pins;
  int n_chk, n_bad, irq_seen;

  sio_wake_chan u_sio_wake_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_sck(pins[0]),
    .tmr_clk(pins[1]), .pre_clk(pins[2]), .sdi(sdi), .cmd_det(cmd_det),
    .bus_rel(bus_rel), .sdo(sdo), .irq(irq)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;
  always @(negedge clk) if (irq) irq_seen++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic bit exp_irq(bit wake, bit [1:0] kind, bit c, bit r,
                                 bit [7:0] rx, bit [7:0] sva);
    if (!wake || kind == 2'b11) return 1'b1;
    return c && r && (rx == sva);
  endfunction

  function automatic bit exp_lsb(bit [1:0] kind, bit b2);
    return !kind[1] && b2;
  endfunction

  // drives eight shift clocks on the selected pin, the others toggle in antiphase
  task automatic run_byte(input bit [1:0] csel, input bit lsb, input bit [7:0] tx,
                          input bit [7:0] rx, input bit chk_sdo, output int n_irq);
    int sel = csel[1] ? (csel[0] ? 2 : 1) : 0;
    int start = irq_seen;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      pins = 3'b111; pins[sel] = 1'b0;
      sdi = lsb ? rx[i] : rx[7-i];
      repeat (4) @(negedge clk);
      if (chk_sdo) check("R9 sdo bit", int'(sdo), int'(lsb ? tx[i] : tx[7-i]));
      pins = 3'b000; pins[sel] = 1'b1;
      repeat (4) @(negedge clk);
    end
    pins = 3'b000;
    repeat (6) @(negedge clk);
    n_irq = irq_seen - start;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int ni;
    n_chk = 0; n_bad = 0; irq_seen = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    pins = 3'b000; sdi = 1'b0; cmd_det = 1'b0; bus_rel = 1'b0;
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); check("R1 mode", d, 8'h00);
    rd(2'd1, d); check("R1 shift", d, 8'h00);
    rd(2'd2, d); check("R1 sva", d, 8'h00);
    check("R1 irq", int'(irq), 0);
    check("R1 sdo", int'(sdo), 0);

    // R3/R4 flag behaviour
    wr(2'd0, 8'h40); rd(2'd0, d); check("R3 R4 bit6 write ignored, off", d, 8'h00);
    wr(2'd0, 8'h80); rd(2'd0, d); check("R3 flag on equal", d, 8'hC0);
    wr(2'd2, 8'h5A); rd(2'd0, d); check("R3 flag off unequal", d, 8'h80);
    rd(2'd2, d); check("R12 sva readback", d, 8'h5A);

    // R2 disabled channel
    wr(2'd0, 8'h00); wr(2'd1, 8'h3C); wr(2'd2, 8'h3C);
    rd(2'd0, d); check("R4 flag low when disabled", d, 8'h00);
    run_byte(2'b00, 1'b0, 8'h3C, 8'hFF, 1'b0, ni);
    rd(2'd1, d); check("R2 no shift when disabled", d, 8'h3C);
    check("R2 no irq when disabled", ni, 0);

    // R11 enabled but no transfer started
    wr(2'd0, 8'h80);
    run_byte(2'b00, 1'b0, 8'h3C, 8'h11, 1'b0, ni);
    rd(2'd1, d); check("R11 no shift without load", d, 8'h3C);
    check("R11 no irq without load", ni, 0);

    // R7 wake ignored in two-wire mode
    cmd_det = 1'b0; bus_rel = 1'b0;
    wr(2'd2, 8'h00); wr(2'd0, 8'hB8 | 8'h02); wr(2'd1, 8'hA5);
    run_byte(2'b10, 1'b0, 8'hA5, 8'h77, 1'b1, ni);
    check("R7 two-wire irq despite wake", ni, 1);
    rd(2'd1, d); check("R9 two-wire msb first", d, 8'h77);

    // R6 wake in bus mode
    wr(2'd2, 8'h42); wr(2'd0, 8'hB0 | 8'h03);
    cmd_det = 1'b1; bus_rel = 1'b1; wr(2'd1, 8'h00);
    run_byte(2'b11, 1'b0, 8'h00, 8'h42, 1'b1, ni);
    check("R6 match with flags", ni, 1);
    rd(2'd0, d); check("R3 flag after match", d, 8'hF3);
    bus_rel = 1'b0; wr(2'd1, 8'h00);
    run_byte(2'b11, 1'b0, 8'h00, 8'h42, 1'b1, ni);
    check("R6 no irq without bus released", ni, 0);
    bus_rel = 1'b1; cmd_det = 1'b0; wr(2'd1, 8'h00);
    run_byte(2'b11, 1'b0, 8'h00, 8'h42, 1'b1, ni);
    check("R6 no irq without command", ni, 0);
    cmd_det = 1'b1; wr(2'd1, 8'h00);
    run_byte(2'b11, 1'b0, 8'h00, 8'h43, 1'b1, ni);
    check("R6 no irq on mismatch", ni, 0);

    // random transfers: R5 R8 R9 R10 R3
    for (int it = 0; it < 24; it++) begin
      bit [7:0] tx, rx, sva, mode;
      bit [1:0] kind, csel;
      bit wake, b2, c, r, lsb;
      tx = 8'($urandom); rx = 8'($urandom);
      kind = 2'($urandom); csel = 2'($urandom);
      wake = 1'($urandom); b2 = 1'($urandom);
      c = 1'($urandom); r = 1'($urandom);
      sva = ($urandom % 2 == 0) ? rx : 8'($urandom);
      mode = {1'b1, 1'b0, wake, kind, b2, csel};
      lsb = exp_lsb(kind, b2);
      cmd_det = c; bus_rel = r;
      wr(2'd2, sva); wr(2'd0, mode); wr(2'd1, tx);
      run_byte(csel, lsb, tx, rx, 1'b1, ni);
      check("R5 R6 R10 irq count", ni, int'(exp_irq(wake, kind, c, r, rx, sva)));
      rd(2'd1, d); check("R8 R9 received byte", d, rx);
      rd(2'd0, d);
      check("R3 mode readback", d, {mode[7], (rx == sva), mode[5:0]});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule